// File: doc/BRIEF.md
# Constant Off-Time Gate Controller

This block is the digital switching core of a peak-current buck LED driver. It drives a single gate output. The gate is switched on and stays on until a current-sense comparator reports that the inductor current has reached its threshold. The gate then stays off for a fixed number of clock cycles and switches on again, so each switching period is set by the time to reach peak current plus a constant off window.

Two sense comparators arrive as digital flags, one against a fixed threshold and one against a scaled dimming threshold. They are ORed, so whichever threshold is lower ends the on phase. For a short window after every rising gate edge the trip flags are ignored. This keeps the discharge spike of the switch from ending the pulse early. An over-current flag ends the pulse in the same way but starts a much longer off window. An over-temperature flag forces the gate off until a separate cool-down flag reports that the temperature has fallen through its hysteresis band. A PWM-level enable input blanks the gate immediately without disturbing the controller, so switching resumes at once when the enable returns.

All windows are parameters in clock cycles: `BLANK_CYC` for blanking, `TOFF_CYC` for the normal off time and `OCP_CYC` for the over-current off time.

Top module: `cot_gate_ctrl`

## Requirements
- R1: While reset is held and after it is released, the controller is in the on state (ctrlState = 0). The gate therefore follows dimEn from the first cycle.
- R2: When the gate is high and unblanked, tripFixed or tripScaled (either one alone) makes the controller enter the off state (ctrlState = 1) at the next clock edge, and the gate goes low.
- R3: During the first BLANK_CYC clock edges of each gate-high stretch, tripFixed, tripScaled and ocTrip are ignored and the controller stays in the on state.
- R4: After a sense trip the gate stays low for exactly TOFF_CYC cycles and then returns high on its own.
- R5: An unblanked ocTrip makes the controller enter the over-current state (ctrlState = 2) and keeps the gate low for exactly OCP_CYC cycles. ocTrip takes priority over a sense trip that arrives in the same cycle.
- R6: While dimEn is low, gateOn is low in the same cycle and the state is unchanged. When dimEn returns high, the gate is high in the same cycle and blanking starts again.
- R7: otHot makes the controller enter the thermal state (ctrlState = 3) at the next edge, with the gate low. It leaves that state for the on state only at an edge where otCool is high and otHot is low.
- R8: cycleStart is high in exactly the first cycle of every gate-high stretch and low at all other times.
- R9: otHot takes priority over sense and over-current trips that arrive in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous active-low reset |
| dimEn | input | 1 | PWM-level enable; low forces the gate off |
| tripFixed | input | 1 | Sense comparator flag against the fixed threshold |
| tripScaled | input | 1 | Sense comparator flag against the scaled dimming threshold |
| ocTrip | input | 1 | Over-current comparator flag |
| otHot | input | 1 | Over-temperature flag |
| otCool | input | 1 | Temperature below the release point (hysteresis release) |
| gateOn | output | 1 | Gate drive request |
| cycleStart | output | 1 | One-cycle pulse on every rising gate edge |
| ctrlState | output | 2 | 0 on, 1 off window, 2 over-current window, 3 thermal hold |

## Verification
The bound checker verifies on every cycle the cause-and-effect rules: an unblanked sense trip or over-current trip moves the controller to the matching state, a trip inside the blanking window leaves it on, and over-temperature forces the thermal state. It also checks that dimEn low keeps the gate off, that cycleStart is a single-cycle pulse, and that the normal off window never runs longer than TOFF_CYC. The exact lengths of both off windows, the need for the cool-down flag to leave the thermal state, and the restart of blanking when dimEn returns are shown by the bench scenarios. A per-clock reference model follows those scenarios.

// File: rtl/cot_gate_pkg.sv
package cot_gate_pkg;

  typedef enum logic [1:0] {
    ST_ON  = 2'd0,
    ST_OFF = 2'd1,
    ST_OCP = 2'd2,
    ST_HOT = 2'd3
  } ctrlState_e;

  // strobes from the control FSM to the timer datapath
  typedef struct packed {
    logic gateOn;
    logic loadToff;
    logic loadOcp;
  } dpStrobe_t;

endpackage

// File: rtl/cot_gate_timers.sv
module cot_gate_timers
  import cot_gate_pkg::*;
#(
  parameter int BLANK_CYC = 4,
  parameter int TOFF_CYC  = 10,
  parameter int OCP_CYC   = 40
) (
  input  logic      clk,
  input  logic      rstN,
  input  dpStrobe_t strobe,
  output logic      offDone,
  output logic      blankDone,
  output logic      firstHigh
);
  localparam int MAX_A = (TOFF_CYC > OCP_CYC) ? TOFF_CYC : OCP_CYC;
  localparam int MAX_C = (MAX_A > BLANK_CYC) ? MAX_A : BLANK_CYC;
  localparam int CNT_W = $clog2(MAX_C + 1);
  localparam logic [CNT_W-1:0] TOFF_LD  = CNT_W'(TOFF_CYC - 1);
  localparam logic [CNT_W-1:0] OCP_LD   = CNT_W'(OCP_CYC - 1);
  localparam logic [CNT_W-1:0] BLANK_LM = CNT_W'(BLANK_CYC);

  logic [CNT_W-1:0] offCnt;
  logic [CNT_W-1:0] blankCnt;

  // off-window down counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                offCnt <= '0;
    else if (strobe.loadToff) offCnt <= TOFF_LD;
    else if (strobe.loadOcp)  offCnt <= OCP_LD;
    else if (offCnt != '0)    offCnt <= offCnt - 1'b1;
  end

  // leading-edge blanking counter: counts gate-high cycles, saturates
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   blankCnt <= '0;
    else if (!strobe.gateOn)     blankCnt <= '0;
    else if (blankCnt != BLANK_LM) blankCnt <= blankCnt + 1'b1;
  end

  assign offDone   = (offCnt == '0);
  assign blankDone = (blankCnt == BLANK_LM);
  assign firstHigh = strobe.gateOn && (blankCnt == '0);

endmodule

// File: rtl/cot_gate_fsm.sv
module cot_gate_fsm
  import cot_gate_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       dimEn,
  input  logic       tripFixed,
  input  logic       tripScaled,
  input  logic       ocTrip,
  input  logic       otHot,
  input  logic       otCool,
  input  logic       offDone,
  input  logic       blankDone,
  output dpStrobe_t  strobe,
  output ctrlState_e state
);
  ctrlState_e nxt;
  logic       senseTrip;
  logic       armed;

  assign senseTrip = tripFixed | tripScaled;

  always_comb begin
    strobe          = '0;
    strobe.gateOn   = (state == ST_ON) && dimEn;
    armed           = strobe.gateOn && blankDone;
    nxt             = state;
    if (otHot) begin
      nxt = ST_HOT;
    end else begin
      unique case (state)
        ST_ON: begin
          if (armed && ocTrip) begin
            nxt            = ST_OCP;
            strobe.loadOcp = 1'b1;
          end else if (armed && senseTrip) begin
            nxt             = ST_OFF;
            strobe.loadToff = 1'b1;
          end
        end
        ST_OFF, ST_OCP: if (offDone) nxt = ST_ON;
        ST_HOT:         if (otCool)  nxt = ST_ON;
        default:        nxt = ST_ON;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_ON;
    else       state <= nxt;
  end

endmodule

// File: rtl/cot_gate_ctrl.sv
module cot_gate_ctrl
  import cot_gate_pkg::*;
#(
  parameter int BLANK_CYC = 4,
  parameter int TOFF_CYC  = 10,
  parameter int OCP_CYC   = 40
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       dimEn,
  input  logic       tripFixed,
  input  logic       tripScaled,
  input  logic       ocTrip,
  input  logic       otHot,
  input  logic       otCool,
  output logic       gateOn,
  output logic       cycleStart,
  output logic [1:0] ctrlState
);
  dpStrobe_t  strobe;
  ctrlState_e state;
  logic       offDone;
  logic       blankDone;
  logic       firstHigh;

  cot_gate_fsm u_fsm (
    .clk        (clk),
    .rstN       (rstN),
    .dimEn      (dimEn),
    .tripFixed  (tripFixed),
    .tripScaled (tripScaled),
    .ocTrip     (ocTrip),
    .otHot      (otHot),
    .otCool     (otCool),
    .offDone    (offDone),
    .blankDone  (blankDone),
    .strobe     (strobe),
    .state      (state)
  );

  cot_gate_timers #(
    .BLANK_CYC (BLANK_CYC),
    .TOFF_CYC  (TOFF_CYC),
    .OCP_CYC   (OCP_CYC)
  ) u_timers (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .offDone   (offDone),
    .blankDone (blankDone),
    .firstHigh (firstHigh)
  );

  assign gateOn     = strobe.gateOn;
  assign cycleStart = firstHigh;
  assign ctrlState  = state;

endmodule

// File: rtl/cot_gate_ctrl_chk.sv
module cot_gate_ctrl_chk #(
  parameter int BLANK_CYC = 4,
  parameter int TOFF_CYC  = 10,
  parameter int OCP_CYC   = 40
) (
  input logic       clk,
  input logic       rstN,
  input logic       dimEn,
  input logic       tripFixed,
  input logic       tripScaled,
  input logic       ocTrip,
  input logic       otHot,
  input logic       otCool,
  input logic       gateOn,
  input logic       cycleStart,
  input logic [1:0] ctrlState
);
  int unsigned hiRun;
  int unsigned offRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiRun  <= 0;
      offRun <= 0;
    end else begin
      hiRun  <= !gateOn ? 0 : ((hiRun < BLANK_CYC) ? hiRun + 1 : hiRun);
      offRun <= (ctrlState == 2'd1) ? offRun + 1 : 0;
    end
  end

  AST_SENSE_TRIP_OFF: assert property (@(posedge clk) disable iff (!rstN)
    gateOn && hiRun >= BLANK_CYC && (tripFixed || tripScaled) && !ocTrip && !otHot
    |=> ctrlState == 2'd1 && !gateOn); // R2

  AST_BLANK_IGNORES: assert property (@(posedge clk) disable iff (!rstN)
    gateOn && hiRun < BLANK_CYC && !otHot |=> ctrlState == 2'd0); // R3

  AST_OFF_WINDOW_MAX: assert property (@(posedge clk) disable iff (!rstN)
    ctrlState == 2'd1 |-> offRun < TOFF_CYC); // R4

  AST_OFF_WINDOW_MIN: assert property (@(posedge clk) disable iff (!rstN)
    ctrlState == 2'd1 && offRun < TOFF_CYC - 1 && !otHot |=> ctrlState == 2'd1); // R4

  AST_OC_TRIP: assert property (@(posedge clk) disable iff (!rstN)
    gateOn && hiRun >= BLANK_CYC && ocTrip && !otHot |=> ctrlState == 2'd2); // R5

  AST_DIM_GATES: assert property (@(posedge clk) disable iff (!rstN)
    !dimEn |-> !gateOn); // R6

  AST_HOT_FORCES: assert property (@(posedge clk) disable iff (!rstN)
    otHot |=> ctrlState == 2'd3 && !gateOn); // R7

  AST_HOT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    ctrlState == 2'd3 && !otCool |=> ctrlState == 2'd3); // R7

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    cycleStart |=> !cycleStart); // R8

  AST_START_ON_GATE: assert property (@(posedge clk) disable iff (!rstN)
    cycleStart |-> gateOn && hiRun == 0); // R8

endmodule

bind cot_gate_ctrl cot_gate_ctrl_chk #(
  .BLANK_CYC (BLANK_CYC),
  .TOFF_CYC  (TOFF_CYC),
  .OCP_CYC   (OCP_CYC)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .dimEn      (dimEn),
  .tripFixed  (tripFixed),
  .tripScaled (tripScaled),
  .ocTrip     (ocTrip),
  .otHot      (otHot),
  .otCool     (otCool),
  .gateOn     (gateOn),
  .cycleStart (cycleStart),
  .ctrlState  (ctrlState)
);

// File: tb/cot_gate_ctrl_bench.sv
`timescale 1ns/1ps
module cot_gate_ctrl_bench;
  localparam int BLANK = 4;
  localparam int TOFF  = 10;
  localparam int OCP   = 40;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dimEn = 1'b1;
  logic tripFixed = 1'b0, tripScaled = 1'b0, ocTrip = 1'b0;
  logic otHot = 1'b0, otCool = 1'b0;
  logic gateOn, cycleStart;
  logic [1:0] ctrlState;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 0;
  string phase = "R1";

  // reference model state
  int mState = 0;
  int mTimer = 0;
  int mBlank = 0;

  always #4 clk = ~clk;

  cot_gate_ctrl #(.BLANK_CYC(BLANK), .TOFF_CYC(TOFF), .OCP_CYC(OCP)) u_cot_gate_ctrl (
    .clk(clk), .rstN(rstN), .dimEn(dimEn), .tripFixed(tripFixed), .tripScaled(tripScaled),
    .ocTrip(ocTrip), .otHot(otHot), .otCool(otCool),
    .gateOn(gateOn), .cycleStart(cycleStart), .ctrlState(ctrlState)
  );

  task automatic expectEq(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  // behavioural reference, stepped just after each rising edge
  always begin
    @(posedge clk);
    #1;
    if (!rstN) begin
      mState = 0; mTimer = 0; mBlank = 0;
    end else begin
      automatic bit g = (mState == 0) && dimEn;
      automatic int ns = mState;
      automatic int ld = -1;
      if (otHot) ns = 3;
      else if (mState == 0) begin
        if (g && mBlank >= BLANK) begin
          if (ocTrip) begin ns = 2; ld = OCP - 1; end
          else if (tripFixed || tripScaled) begin ns = 1; ld = TOFF - 1; end
        end
      end else if (mState == 1 || mState == 2) begin
        if (mTimer == 0) ns = 0;
      end else if (otCool) ns = 0;
      if (ld >= 0) mTimer = ld;
      else if (mTimer > 0) mTimer = mTimer - 1;
      if (!g) mBlank = 0;
      else if (mBlank < BLANK) mBlank = mBlank + 1;
      mState = ns;
    end
    begin
      automatic int eg = ((mState == 0) && dimEn) ? 1 : 0;
      automatic int ecs = (eg == 1 && mBlank == 0) ? 1 : 0;
      checks++;
      if (gateOn !== eg[0] || cycleStart !== ecs[0] || ctrlState !== mState[1:0]) begin
        failures++;
        $display("FAIL %s model gate/start/state actual=%0d/%0d/%0d expected=%0d/%0d/%0d t=%0t",
                 phase, gateOn, cycleStart, ctrlState, eg, ecs, mState, $time);
      end
    end
  end

  task automatic waitArmed();
    while (!gateOn) @(negedge clk);
    repeat (BLANK + 1) @(negedge clk);
  endtask

  // pulse trips once unblanked, then measure the low window
  task automatic tripMeasure(input string req, input bit f, input bit s, input bit oc,
                             input int expState, input int expLen);
    int n;
    waitArmed();
    tripFixed = f; tripScaled = s; ocTrip = oc;
    @(negedge clk);
    tripFixed = 0; tripScaled = 0; ocTrip = 0;
    #1;
    expectEq(req, ctrlState, expState, "state after trip");
    n = 0;
    while (!gateOn && n < 1000) begin
      n++;
      @(negedge clk);
      #1;
    end
    expectEq(req, n, expLen, "gate-low cycles");
    expectEq("R8", cycleStart, 1, "cycleStart on re-entry");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    phase = "R1";
    expectEq("R1", ctrlState, 0, "state in reset");
    expectEq("R1", gateOn, 1, "gate in reset");
    rstN = 1'b1;
    @(negedge clk); #1;
    expectEq("R1", ctrlState, 0, "state after reset");
    expectEq("R1", gateOn, 1, "gate after reset");

    phase = "R2";
    tripMeasure("R2", 1, 0, 0, 1, TOFF);
    phase = "R4";
    tripMeasure("R4", 0, 1, 0, 1, TOFF);

    // R3: trips held across the whole blanking window are ignored
    phase = "R3";
    tripFixed = 1; tripScaled = 1; ocTrip = 1;
    repeat (BLANK) @(negedge clk);
    tripFixed = 0; tripScaled = 0; ocTrip = 0;
    #1;
    expectEq("R3", ctrlState, 0, "state after blanked trips");
    expectEq("R3", gateOn, 1, "gate after blanked trips");

    phase = "R5";
    tripMeasure("R5", 1, 1, 1, 2, OCP);

    // R6: dimming enable gates immediately, blanking restarts
    phase = "R6";
    waitArmed();
    dimEn = 0; #1;
    expectEq("R6", gateOn, 0, "gate while dim low");
    repeat (3) @(negedge clk);
    #1;
    expectEq("R6", ctrlState, 0, "state while dim low");
    dimEn = 1; #1;
    expectEq("R6", gateOn, 1, "gate on dim return");
    expectEq("R8", cycleStart, 1, "cycleStart on dim return");
    tripFixed = 1;
    @(negedge clk);
    tripFixed = 0; #1;
    expectEq("R6", ctrlState, 0, "blanking restarted after dim");
    @(negedge clk); #1;
    expectEq("R8", cycleStart, 0, "cycleStart single cycle");

    // R7: thermal hold and hysteresis release
    phase = "R7";
    otHot = 1;
    @(negedge clk); #1;
    expectEq("R7", ctrlState, 3, "state on otHot");
    expectEq("R7", gateOn, 0, "gate on otHot");
    otHot = 0;
    repeat (3) @(negedge clk);
    #1;
    expectEq("R7", ctrlState, 3, "hold without otCool");
    otCool = 1;
    @(negedge clk);
    otCool = 0; #1;
    expectEq("R7", ctrlState, 0, "release on otCool");
    expectEq("R7", gateOn, 1, "gate after release");

    // R9: thermal beats a simultaneous over-current trip
    phase = "R9";
    waitArmed();
    otHot = 1; ocTrip = 1; tripFixed = 1;
    @(negedge clk);
    otHot = 0; ocTrip = 0; tripFixed = 0; #1;
    expectEq("R9", ctrlState, 3, "thermal priority");
    otCool = 1;
    @(negedge clk);
    otCool = 0;
    repeat (5) @(negedge clk);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected<20000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule